// File: doc/BRIEF.md
# Banked Monitor Register File Port

This block is the host-facing register file of a hardware monitoring device. It sits behind an eight-byte I/O window. Two offsets of that window are used. One holds a pointer into the register space. The other reads or writes the register that the pointer selects. All other offsets return all-ones and take no action on a write.

A host sets the pointer and then moves data through the data offset. For a fixed set of counter-style and value-RAM locations, the pointer steps forward by itself after each data access. A run of value-RAM bytes can therefore be fetched without reloading the pointer. A second address window mirrors the value RAM.

A bank field selects what the eight page-switched locations show. A single location returns either byte of the vendor identifier, chosen by one bit of the bank register. Analog readings enter as plain input buses and are scaled when they are read. A configuration bit restores the register defaults but keeps the programmed serial-bus address.

The data offset uses single-cycle read and write strobes. Valid/ready handshaking does not apply here. Read data is combinational from the current pointer and offset during the strobe cycle.

Top module: `hwmon_regport`

## Requirements
- R1: A write to offset 5 loads the pointer with the low 7 bits of the write data. A read at offset 5 returns the pointer with bit 7 at zero.
- R2: At offsets 0–4 and 7, a read returns 0xFF. A write at those offsets changes neither the pointer nor any register.
- R3: When the bank is 0, a read or write at offset 6 advances the pointer by one on the same clock edge. This happens only if the pointer is 0x41, 0x43, 0x45 or 0x56, or lies from 0x60 to 0x93 (0x7F wraps to 0x00). At any other pointer value, the pointer holds.
- R4: When the bank is not 0, a data access never advances the pointer.
- R5: Pointer values 0x60 and above map to the register at (pointer AND 0x3F), for both reads and writes.
- R6: The bank is bits [2:0] of register 0x4E. When the bank is not 0, locations 0x50–0x57 read 0x00 and ignore writes. Register 0x4E reads and writes normally in every bank.
- R7: A read of location 0x4F returns 0x5C when bit 7 of register 0x4E is 1. It returns 0xA3 when that bit is 0.
- R8: Writes have no effect on any of these locations:
  - 0x00–0x05
  - 0x20–0x2A
  - 0x41, 0x42, 0x4F and 0x58
  - 0x60–0x6A
- R9: Writing location 0x40 with bit 7 set restores every register to its reset value, except register 0x48, which keeps its current contents. The pointer is not changed.
- R10: After reset, the pointer is 0 and the registers hold these values:
  - 0x40 = 0x08
  - 0x46 = 0x40
  - 0x47 = 0x50
  - 0x48 = the bus-address parameter (default 0x2D)
  - 0x49 = 0x02
  - 0x4E = 0x80
  - every other register = 0x00
- R11: A read of 0x20–0x26 (or their mirrors 0x60–0x66) returns bits [11:4] of the matching millivolt input, channels 0–6. A read of 0x27 returns the temperature input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_off | input | 3 | Offset within the I/O window |
| port_rd | input | 1 | Single-cycle read strobe |
| port_wr | input | 1 | Single-cycle write strobe |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Read data, combinational during the strobe cycle |
| volt_mv | input | NUM_VOLT x MV_W | Voltage channels in millivolts |
| temp0 | input | 8 | Temperature channel 0 |

## Verification
Several wrong internal states appear at the ports one data access after they occur:
- A wrong pointer-advance decision shows up when offset 5 is read back, or when the next data read lands on the wrong register.
- A bad alias or a read-only decode shows up on the read that follows the write into the mirrored or protected location.
- A corrupted bank register changes both the vendor byte at 0x4F and the page-switched locations on the next read.

A soft reset that also cleared the bus address appears on the first read of 0x48 afterwards.

// File: rtl/hwmon_regport_pkg.sv
package hwmon_regport_pkg;
  localparam logic [2:0] OFF_IDX  = 3'd5;
  localparam logic [2:0] OFF_DATA = 3'd6;
  localparam logic [7:0] A_CFG    = 8'h40;
  localparam logic [7:0] A_BUSADR = 8'h48;
  localparam logic [7:0] A_BANK   = 8'h4E;
  localparam logic [7:0] A_VID    = 8'h4F;
  localparam logic [7:0] VID_HI   = 8'h5C;
  localparam logic [7:0] VID_LO   = 8'hA3;

  function automatic logic is_ro(input logic [7:0] a);
    return (a <= 8'h05) || (a >= 8'h20 && a <= 8'h2A) || a == 8'h41 || a == 8'h42 ||
           a == 8'h4F || a == 8'h58 || (a >= 8'h60 && a <= 8'h6A) ||
           (a >= 8'h80 && a <= 8'h85);
  endfunction

  function automatic logic is_autoinc(input logic [7:0] a);
    return a == 8'h41 || a == 8'h43 || a == 8'h45 || a == 8'h56 ||
           (a >= 8'h60 && a <= 8'h93);
  endfunction

  function automatic logic [7:0] alias_of(input logic [7:0] a);
    return (a >= 8'h60 && a <= 8'h94) ? (a & 8'h3F) : a;
  endfunction

  function automatic logic is_paged(input logic [7:0] a);
    return a[7:3] == 5'b01010;
  endfunction

  function automatic logic [7:0] rst_val(input logic [7:0] a, input logic [7:0] busadr);
    case (a)
      8'h40:   return 8'h08;
      8'h46:   return 8'h40;
      8'h47:   return 8'h50;
      8'h48:   return busadr;
      8'h49:   return 8'h02;
      8'h4E:   return 8'h80;
      default: return (a >= 8'hC0 && a <= 8'hDF) ? 8'hFF : 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hwmon_regport_index.sv
module hwmon_regport_index
  import hwmon_regport_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [7:0]       load_val,
  input  logic             data_acc,
  input  logic             bank_zero,
  output logic [IDX_W-1:0] idx
);
  logic step;
  assign step = data_acc && bank_zero && is_autoinc(8'(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx <= '0;
    else if (idx_load) idx <= load_val[IDX_W-1:0];
    else if (step)     idx <= idx + 1'b1;
  end
endmodule

// File: rtl/hwmon_regport_array.sv
module hwmon_regport_array
  import hwmon_regport_pkg::*;
#(
  parameter int         IDX_W    = 7,
  parameter logic [7:0] BUS_ADDR = 8'h2D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_ptr,
  input  logic [7:0]       wdata,
  input  logic             bank_zero,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_byte,
  output logic [7:0]       bank_byte
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH*8-1:0] flat;
  logic [7:0]         eff;
  logic               allowed;
  logic               commit;
  logic               soft_rst;

  assign eff      = alias_of(8'(wr_ptr));
  assign allowed  = !is_ro(8'(wr_ptr)) && !(!bank_zero && is_paged(8'(wr_ptr)));
  assign commit   = wr_en && allowed;
  assign soft_rst = commit && eff == A_CFG && wdata[7];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= rst_val(8'(g), BUS_ADDR);
      else if (soft_rst)
        q <= (8'(g) == A_BUSADR) ? q : rst_val(8'(g), BUS_ADDR);
      else if (commit && eff == 8'(g))
        q <= wdata;
    end
    assign flat[g*8 +: 8] = q;
  end

  assign rd_byte   = flat[{rd_addr, 3'b000} +: 8];
  assign bank_byte = flat[A_BANK[IDX_W-1:0]*8 +: 8];
endmodule

// File: rtl/hwmon_regport_readmux.sv
module hwmon_regport_readmux
  import hwmon_regport_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int NUM_VOLT = 7,
  parameter int MV_W     = 16
) (
  input  logic [2:0]                   off,
  input  logic [IDX_W-1:0]             idx,
  input  logic [7:0]                   bank_byte,
  input  logic [7:0]                   stored,
  input  logic [NUM_VOLT-1:0][MV_W-1:0] volt_mv,
  input  logic [7:0]                   temp0,
  output logic [7:0]                   rdata
);
  logic [7:0]      ptr;
  logic [7:0]      eff;
  logic [7:0]      data;
  logic [MV_W-1:0] vsel;

  assign ptr  = 8'(idx);
  assign eff  = alias_of(ptr);
  assign vsel = volt_mv[eff[2:0]];

  always_comb begin
    if (bank_byte[2:0] != 3'd0 && is_paged(ptr))  data = 8'h00;
    else if (eff >= 8'h20 && eff <= 8'h26)         data = vsel[4 +: 8];
    else if (eff == 8'h27)                         data = temp0;
    else if (ptr == A_VID)                         data = bank_byte[7] ? VID_HI : VID_LO;
    else                                           data = stored;
  end

  always_comb begin
    case (off)
      OFF_IDX:  rdata = ptr;
      OFF_DATA: rdata = data;
      default:  rdata = 8'hFF;
    endcase
  end
endmodule

// File: rtl/hwmon_regport.sv
module hwmon_regport
  import hwmon_regport_pkg::*;
#(
  parameter int         IDX_W    = 7,
  parameter int         NUM_VOLT = 7,
  parameter int         MV_W     = 16,
  parameter logic [7:0] BUS_ADDR = 8'h2D
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   port_off,
  input  logic                         port_rd,
  input  logic                         port_wr,
  input  logic [7:0]                   port_wdata,
  output logic [7:0]                   port_rdata,
  input  logic [NUM_VOLT-1:0][MV_W-1:0] volt_mv,
  input  logic [7:0]                   temp0
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] rd_addr;
  logic [7:0]       stored;
  logic [7:0]       bank_byte;
  logic             bank_zero;
  logic             at_data;

  assign at_data   = port_off == OFF_DATA;
  assign bank_zero = bank_byte[2:0] == 3'd0;
  assign rd_addr   = alias_of(8'(idx_q))[IDX_W-1:0];

  hwmon_regport_index #(.IDX_W(IDX_W)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_load (port_wr && port_off == OFF_IDX),
    .load_val (port_wdata),
    .data_acc (at_data && (port_rd || port_wr)),
    .bank_zero(bank_zero),
    .idx      (idx_q)
  );

  hwmon_regport_array #(.IDX_W(IDX_W), .BUS_ADDR(BUS_ADDR)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (port_wr && at_data),
    .wr_ptr   (idx_q),
    .wdata    (port_wdata),
    .bank_zero(bank_zero),
    .rd_addr  (rd_addr),
    .rd_byte  (stored),
    .bank_byte(bank_byte)
  );

  hwmon_regport_readmux #(.IDX_W(IDX_W), .NUM_VOLT(NUM_VOLT), .MV_W(MV_W)) u_readmux (
    .off      (port_off),
    .idx      (idx_q),
    .bank_byte(bank_byte),
    .stored   (stored),
    .volt_mv  (volt_mv),
    .temp0    (temp0),
    .rdata    (port_rdata)
  );
endmodule

// File: rtl/hwmon_regport_chk.sv
module hwmon_regport_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       port_off,
  input logic             port_rd,
  input logic             port_wr,
  input logic [7:0]       port_rdata,
  input logic [IDX_W-1:0] idx,
  input logic [7:0]       bank_byte
);
  logic acc;
  assign acc = port_rd || port_wr;

  assert_idx_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off == 3'd5) |-> (port_rdata[7] == 1'b0));

  assert_unused_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off != 3'd5 && port_off != 3'd6) |-> (port_rdata == 8'hFF));

  assert_unused_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && port_off != 3'd5 && port_off != 3'd6) |=> $stable(idx));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && port_off == 3'd6 && bank_byte[2:0] == 3'd0 && idx == 7'h41) |=> (idx == 7'h42));

  assert_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && port_off == 3'd6 && bank_byte[2:0] != 3'd0) |=> $stable(idx));

  assert_vendor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off == 3'd6 && idx == 7'h4F) |->
      (port_rdata == (bank_byte[7] ? 8'h5C : 8'hA3)));
endmodule

bind hwmon_regport hwmon_regport_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_off  (port_off),
  .port_rd   (port_rd),
  .port_wr   (port_wr),
  .port_rdata(port_rdata),
  .idx       (idx_q),
  .bank_byte (bank_byte)
);

// File: tb/test_hwmon_regport.sv
module test_hwmon_regport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] port_off = '0;
  logic port_rd = 1'b0;
  logic port_wr = 1'b0;
  logic [7:0] port_wdata = '0;
  logic [7:0] port_rdata;
  logic [6:0][15:0] volt_mv;
  logic [7:0] temp0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hwmon_regport i_hwmon_regport (
    .clk(clk), .rst_n(rst_n), .port_off(port_off), .port_rd(port_rd),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .volt_mv(volt_mv), .temp0(temp0)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] off, input logic [7:0] v);
    @(negedge clk); port_off = off; port_wdata = v; port_wr = 1'b1;
    @(negedge clk); port_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] off, output logic [7:0] v);
    @(negedge clk); port_off = off; port_rd = 1'b1;
    #1 v = port_rdata;
    @(negedge clk); port_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] v);
    bus_wr(3'd5, a); bus_wr(3'd6, v);
  endtask

  task automatic reg_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_wr(3'd5, a); bus_rd(3'd6, v); check(tag, v, exp);
  endtask

  task automatic idx_chk(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(3'd5, v); check(tag, v, exp);
  endtask

  task automatic t_reset_R10;
    idx_chk("R10 pointer", 8'h00);
    reg_chk("R10 0x40", 8'h40, 8'h08);
    reg_chk("R10 0x46", 8'h46, 8'h40);
    reg_chk("R10 0x47", 8'h47, 8'h50);
    reg_chk("R10 0x48", 8'h48, 8'h2D);
    reg_chk("R10 0x49", 8'h49, 8'h02);
    reg_chk("R10 0x4E", 8'h4E, 8'h80);
    reg_chk("R10 0x10", 8'h10, 8'h00);
  endtask

  task automatic t_index_R1;
    bus_wr(3'd5, 8'hFF);
    idx_chk("R1 mask", 8'h7F);
    bus_wr(3'd5, 8'h9A);
    idx_chk("R1 mask2", 8'h1A);
  endtask

  task automatic t_unused_R2;
    logic [7:0] v;
    reg_wr(8'h10, 8'h55);
    bus_wr(3'd5, 8'h10);
    bus_wr(3'd3, 8'hAA);
    bus_wr(3'd7, 8'h33);
    bus_rd(3'd3, v); check("R2 read ff", v, 8'hFF);
    bus_rd(3'd0, v); check("R2 read ff off0", v, 8'hFF);
    idx_chk("R2 pointer held", 8'h10);
    bus_rd(3'd6, v); check("R2 data held", v, 8'h55);
  endtask

  task automatic t_step_R3_R5;
    logic [7:0] v;
    bus_wr(3'd5, 8'h41); bus_rd(3'd6, v);
    idx_chk("R3 step 41", 8'h42);
    bus_wr(3'd5, 8'h40); bus_rd(3'd6, v);
    idx_chk("R3 hold 40", 8'h40);
    reg_wr(8'h70, 8'h11);
    idx_chk("R3 step on write 70", 8'h71);
    reg_chk("R5 alias write", 8'h30, 8'h11);
    reg_wr(8'h31, 8'h22);
    reg_chk("R5 alias read", 8'h71, 8'h22);
    idx_chk("R3 step after 71", 8'h72);
    bus_wr(3'd5, 8'h7F); bus_rd(3'd6, v);
    idx_chk("R3 wrap", 8'h00);
  endtask

  task automatic t_readonly_R8;
    reg_wr(8'h42, 8'h99); reg_chk("R8 0x42", 8'h42, 8'h00);
    reg_wr(8'h58, 8'h77); reg_chk("R8 0x58", 8'h58, 8'h00);
    reg_wr(8'h02, 8'h33); reg_chk("R8 0x02", 8'h02, 8'h00);
    reg_wr(8'h6A, 8'h44); reg_chk("R8 0x6A mirror", 8'h2A, 8'h00);
    reg_wr(8'h6B, 8'h45); reg_chk("R8 0x6B writable", 8'h2B, 8'h45);
  endtask

  task automatic t_sensor_R11;
    reg_chk("R11 volt3", 8'h23, 8'hC8);
    reg_chk("R11 volt6 mirror", 8'h66, 8'h4E);
    reg_chk("R11 volt0", 8'h20, 8'h70);
    reg_chk("R11 temp", 8'h27, 8'h1E);
  endtask

  task automatic t_vendor_R7;
    reg_chk("R7 high byte", 8'h4F, 8'h5C);
    reg_wr(8'h4E, 8'h00);
    reg_chk("R7 low byte", 8'h4F, 8'hA3);
    reg_wr(8'h4E, 8'h80);
  endtask

  task automatic t_bank_R4_R6;
    logic [7:0] v;
    reg_wr(8'h4E, 8'h81);
    reg_wr(8'h50, 8'h12);
    reg_chk("R6 paged reads zero", 8'h50, 8'h00);
    reg_chk("R6 bank reg reachable", 8'h4E, 8'h81);
    bus_wr(3'd5, 8'h41); bus_rd(3'd6, v);
    idx_chk("R4 no step", 8'h41);
    reg_wr(8'h4E, 8'h80);
    reg_chk("R6 write ignored", 8'h50, 8'h00);
    reg_wr(8'h50, 8'h12);
    reg_chk("R6 bank0 normal", 8'h50, 8'h12);
  endtask

  task automatic t_soft_R9;
    reg_wr(8'h48, 8'h33);
    reg_wr(8'h10, 8'h5A);
    reg_wr(8'h4E, 8'h03);
    reg_wr(8'h40, 8'h80);
    idx_chk("R9 pointer kept", 8'h40);
    reg_chk("R9 0x40", 8'h40, 8'h08);
    reg_chk("R9 0x10 cleared", 8'h10, 8'h00);
    reg_chk("R9 0x48 kept", 8'h48, 8'h33);
    reg_chk("R9 0x4E default", 8'h4E, 8'h80);
    reg_chk("R9 0x50 cleared", 8'h50, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    volt_mv = '0;
    volt_mv[0] = 16'd1800;
    volt_mv[3] = 16'd3200;
    volt_mv[6] = 16'd1250;
    temp0 = 8'h1E;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_R10();
    t_index_R1();
    t_unused_R2();
    t_step_R3_R5();
    t_readonly_R8();
    t_sensor_R11();
    t_vendor_R7();
    t_bank_R4_R6();
    t_soft_R9();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule